// File: doc/BRIEF.md
# Three-Level Interrupt Priority Controller

This block arbitrates interrupt requests for a small microcontroller core and decides which source the core vectors to next. It holds a flag register for a set of maskable sources, each with its own enable bit and a high/low priority select, plus one level-sensitive power-fail input that lives alone on a fixed top level. A global enable gates the maskable sources. It does not gate power-fail, which answers only to its own enable.

The controller keeps one in-service bit per level. It raises a single-cycle acknowledge with the winning source index and level. The core ends a routine by pulsing a return input, which clears the highest in-service level. Software can overwrite the flag register to force or cancel requests. The flag of the last source is a real-time clock flag, and software can only clear it.

The acknowledge is an event with no back-pressure. The core must take it in the cycle it appears, and the controller never waits for a ready signal. All other pins are plain control and status.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, flags, the power-fail flag, the in-service bits and the acknowledge are all 0.
- R2: An acknowledge lasts exactly one cycle and carries the source index (power-fail is index NSRC) and the level code (0 none, 1 low, 2 high, 3 top). It clears the flag of the acknowledged maskable source. No new acknowledge is raised in the cycle right after an acknowledge.
- R3: Among pending requests of the same level, the lowest source index wins.
- R4: A source whose priority bit is 1 is at level 2. A source whose priority bit is 0 is at level 1. A pending level-2 request wins over any level-1 request, whatever their indices.
- R5: A request is acknowledged only if its level is strictly above the highest level in service. Requests at an equal or lower level stay pending.
- R6: Power-fail is acknowledged at level 3 when its enable is 1, even when the global enable is 0. A maskable source needs its own enable bit and the global enable.
- R7: The power-fail flag follows the power-fail input one cycle later. It is not cleared by an acknowledge, so it requests again after a return while the input stays active.
- R8: A software write loads the flag register. A 1 written to a flag forces a request that is serviced like a hardware one.
- R9: Writing 0 to a flag before its acknowledge cancels the request. Writing after the acknowledge leaves the in-service state unchanged.
- R10: A software write cannot set the real-time clock flag (index NSRC-1), though it can clear it. A hardware event can still set it.
- R11: A return pulse clears only the highest set in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_set | input | NSRC | Hardware event pulses that set source flags |
| pf_active | input | 1 | Power-fail condition, level-sensitive |
| pf_en | input | 1 | Power-fail enable |
| glob_en | input | 1 | Global enable for maskable sources |
| src_en | input | NSRC | Per-source enables |
| src_hi | input | NSRC | Per-source priority select, 1 = high |
| sw_wr | input | 1 | Software write strobe for the flag register |
| sw_wdata | input | NSRC | Software write data |
| reti | input | 1 | Return-from-interrupt pulse |
| flags | output | NSRC | Current source flags |
| pf_flag | output | 1 | Current power-fail flag |
| ack | output | 1 | One-cycle acknowledge |
| ack_id | output | $clog2(NSRC+1) | Acknowledged source index |
| ack_lvl | output | 2 | Acknowledged level code |
| in_svc | output | 3 | In-service bits, bit 0 low to bit 2 top |

## Verification
The bench builds the block with NSRC = 6. That gives a 3-bit index with the power-fail code 6 and puts the real-time clock flag at index 5, so one source can be driven as both a high-priority preemptor and a flag that software cannot set. With six sources, simultaneous pairs can be placed at both ends of the natural order. The bench also fills all three in-service levels, which exercises the power-fail re-request after a return.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  function automatic lvl_e svc_level(input logic [2:0] svc);
    if (svc[2])      return LVL_TOP;
    else if (svc[1]) return LVL_HIGH;
    else if (svc[0]) return LVL_LOW;
    else             return LVL_NONE;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC    = 6,
  parameter int RTC_IDX = NSRC - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_set,
  input  logic            sw_wr,
  input  logic [NSRC-1:0] sw_wdata,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] kept, nxt;

  always_comb begin
    kept = flags & ~clr_mask;
    nxt  = kept;
    if (sw_wr) begin
      nxt = sw_wdata;
      nxt[RTC_IDX] = sw_wdata[RTC_IDX] & kept[RTC_IDX];
    end
    nxt = nxt | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  // R10: software alone never raises the clock flag
  a_r10_rtc_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !flags[RTC_IDX] && !hw_set[RTC_IDX]) |=> !flags[RTC_IDX]);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  lvl_e       push_lvl,
  input  logic       pop,
  output logic [2:0] svc
);
  logic [2:0] nxt;

  always_comb begin
    nxt = svc;
    if (pop) begin
      if (nxt[2])      nxt[2] = 1'b0;
      else if (nxt[1]) nxt[1] = 1'b0;
      else             nxt[0] = 1'b0;
    end
    if (push) begin
      case (push_lvl)
        LVL_TOP:  nxt[2] = 1'b1;
        LVL_HIGH: nxt[1] = 1'b1;
        LVL_LOW:  nxt[0] = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc <= '0;
    else        svc <= nxt;
  end

  // R5: a new level must sit strictly above the level in service
  a_r5_push_above: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_lvl > svc_level(svc)));
  // R11: a return removes exactly one level
  a_r11_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && svc != 3'b000) |=> ($countones(svc) == $countones($past(svc)) - 1));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 6,
  localparam int IW  = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_set,
  input  logic            pf_active,
  input  logic            pf_en,
  input  logic            glob_en,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic            sw_wr,
  input  logic [NSRC-1:0] sw_wdata,
  input  logic            reti,
  output logic [NSRC-1:0] flags,
  output logic            pf_flag,
  output logic            ack,
  output logic [IW-1:0]   ack_id,
  output logic [1:0]      ack_lvl,
  output logic [2:0]      in_svc
);
  localparam logic [IW-1:0] PF_ID = IW'(NSRC);

  logic [NSRC-1:0] elig_hi, elig_lo, clr_mask;
  logic            any_hi, any_lo, grant;
  logic [IW-1:0]   idx_hi, idx_lo, cand_id;
  lvl_e            cand_lvl, cur_lvl;

  irq_flag_bank #(.NSRC(NSRC), .RTC_IDX(NSRC - 1)) u_flags (
    .clk, .rst_n, .hw_set, .sw_wr, .sw_wdata, .clr_mask, .flags
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf_flag <= 1'b0;
    else        pf_flag <= pf_active;
  end

  assign elig_hi = flags & src_en &  src_hi & {NSRC{glob_en}};
  assign elig_lo = flags & src_en & ~src_hi & {NSRC{glob_en}};

  irq_pick #(.N(NSRC), .IW(IW)) u_pick_hi (.req(elig_hi), .any(any_hi), .idx(idx_hi));
  irq_pick #(.N(NSRC), .IW(IW)) u_pick_lo (.req(elig_lo), .any(any_lo), .idx(idx_lo));

  always_comb begin
    if (pf_flag && pf_en) begin
      cand_lvl = LVL_TOP;  cand_id = PF_ID;
    end else if (any_hi) begin
      cand_lvl = LVL_HIGH; cand_id = idx_hi;
    end else if (any_lo) begin
      cand_lvl = LVL_LOW;  cand_id = idx_lo;
    end else begin
      cand_lvl = LVL_NONE; cand_id = '0;
    end
  end

  assign cur_lvl  = svc_level(in_svc);
  assign grant    = (cand_lvl > cur_lvl) && !ack;
  assign clr_mask = (grant && cand_lvl != LVL_TOP) ? (NSRC'(1) << cand_id) : '0;

  irq_svc_track u_svc (
    .clk, .rst_n, .push(grant), .push_lvl(cand_lvl), .pop(reti), .svc(in_svc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      ack_id  <= '0;
      ack_lvl <= 2'd0;
    end else begin
      ack <= grant;
      if (grant) begin
        ack_id  <= cand_id;
        ack_lvl <= cand_lvl;
      end
    end
  end

  // R2: acknowledge is a single-cycle pulse
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R6: only power-fail reaches the top level
  a_r6_top_only_pf: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_lvl == 2'd3) |-> (ack_id == PF_ID));
  // R6: maskable acknowledges require the global enable
  a_r6_mask_needs_glob: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_lvl != 2'd3) |-> $past(glob_en));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int NSRC = 6;
  localparam int IW   = $clog2(NSRC + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] hw_set = '0, src_en = '1, src_hi = '0, sw_wdata = '0;
  logic pf_active = 0, pf_en = 1, glob_en = 1, sw_wr = 0, reti = 0;
  logic [NSRC-1:0] flags;
  logic pf_flag, ack;
  logic [IW-1:0] ack_id;
  logic [1:0] ack_lvl;
  logic [2:0] in_svc;

  int checks = 0, errors = 0;
  logic [IW+1:0] expq[$];

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC)) u_irq_prio_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ack(input int id, input int lvl);
    expq.push_back({IW'(id), 2'(lvl)});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_hw(input logic [NSRC-1:0] m);
    hw_set = m; cyc(1); hw_set = '0;
  endtask

  task automatic sw_write(input logic [NSRC-1:0] d);
    sw_wdata = d; sw_wr = 1; cyc(1); sw_wr = 0;
  endtask

  task automatic do_reti();
    reti = 1; cyc(1); reti = 0; cyc(1);
  endtask

  // monitor: compare every acknowledge against the scoreboard
  always @(negedge clk) begin
    if (rst_n && ack) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected ack actual=%0d/%0d expected=none", ack_id, ack_lvl);
      end else begin
        logic [IW+1:0] e;
        e = expq.pop_front();
        if ({ack_id, ack_lvl} !== e) begin
          errors++;
          $display("FAIL R2 ack id/lvl actual=%0d/%0d expected=%0d/%0d",
                   ack_id, ack_lvl, e[IW+1:2], e[1:0]);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    check("R1 flags", flags, 0);
    check("R1 pf_flag", pf_flag, 0);
    check("R1 in_svc", in_svc, 0);
    check("R1 ack", ack, 0);
    rst_n = 1; cyc(2);

    // R3: simultaneous low requests, lowest index first; R5 equal level waits
    expect_ack(1, 1);
    pulse_hw(6'b001010); cyc(5);
    check("R2 acked flag cleared", flags, 6'b001000);
    check("R5 equal level held", in_svc, 3'b001);
    expect_ack(3, 1);
    do_reti(); cyc(4);
    do_reti();
    check("R11 all popped", in_svc, 0);

    // R4: high beats low regardless of index
    src_hi = 6'b010000;
    expect_ack(4, 2);
    pulse_hw(6'b010001); cyc(5);
    check("R4 high in service", in_svc, 3'b010);
    expect_ack(0, 1);
    do_reti(); cyc(4); do_reti();

    // R5 preemption chain, R6 pf ignores glob_en, R7 re-request, R11
    src_hi = 6'b100000;
    expect_ack(2, 1); pulse_hw(6'b000100); cyc(4);
    expect_ack(5, 2); pulse_hw(6'b100000); cyc(4);
    check("R5 nested", in_svc, 3'b011);
    glob_en = 0;
    expect_ack(6, 3); pf_active = 1; cyc(6);
    check("R6 top in service", in_svc, 3'b111);
    check("R7 pf flag held", pf_flag, 1);
    expect_ack(6, 3);
    do_reti(); cyc(4);
    check("R7 pf re-acked", in_svc, 3'b111);
    pf_active = 0; cyc(2);
    do_reti();
    check("R11 top popped only", in_svc, 3'b011);
    do_reti(); do_reti();
    check("R11 empty", in_svc, 0);

    // R6/R9: maskable blocked by glob_en, then cancelled by software clear
    sw_write(6'b000100); cyc(3);
    check("R8 sw set", flags, 6'b000100);
    sw_write(6'b000000);
    glob_en = 1; cyc(5);
    check("R9 cancelled", flags, 0);
    check("R9 no service", in_svc, 0);

    // R6: src_en blocks
    src_en = 6'b111110;
    pulse_hw(6'b000001); cyc(4);
    check("R6 src disabled", in_svc, 0);
    src_en = '1;
    expect_ack(0, 1); cyc(4); do_reti();

    // R10: software cannot set the clock flag, hardware can
    sw_write(6'b100000); cyc(2);
    check("R10 rtc not set", flags, 0);
    src_hi = '0;
    expect_ack(5, 1); pulse_hw(6'b100000); cyc(4);
    check("R10 hw rtc served", in_svc, 3'b001);
    do_reti();

    // R8 forced request, R9 late clear has no effect
    expect_ack(3, 1); sw_write(6'b001000); cyc(4);
    sw_write(6'b000000); cyc(2);
    check("R9 late clear keeps service", in_svc, 3'b001);
    do_reti(); cyc(3);

    check("R2 scoreboard drained", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule